// File: doc/BRIEF.md
# Main Clock Loss Supervisor

This block watches a main clock from a free-running on-chip oscillator clock and, when the main clock goes quiet while supervision is armed, moves the system clock selection over to the oscillator without software involvement. All of its state lives in the oscillator domain. The main clock enters only through a toggle flop and a synchronizer that turns each main-clock rising edge into a one-cycle pulse.

Software sees one byte-wide register. The low two bits arm supervision, and only the code 11 counts as armed. Bit 2 picks the system clock, where 1 means the oscillator. Bit 3 is a read-only flag that is set while the main clock is judged lost. Bits 7:4 always read 0. A write counts only when the external protect-enable input is high. While the loss flag is up, software cannot move the select back to the main clock. The block also forces the low-speed oscillator's off request to 0 whenever the oscillator is selected.

The detector is a four-state machine:
- DET_OFF is entered whenever the enable field is not 11.
- From DET_OFF it goes to DET_RUN on the first armed cycle.
- DET_RUN moves to DET_LOST after TIMEOUT consecutive oscillator cycles with no synchronized edge. This is the stop event.
- DET_LOST moves on its first edge to DET_RETURN, or straight to DET_RUN when RECOVER is 1.
- DET_RETURN goes back to DET_RUN after RECOVER consecutive edges, each arriving within TIMEOUT cycles of the previous one.
- DET_RETURN falls back to DET_LOST if an edge gap reaches TIMEOUT.
- The loss flag is high in DET_LOST and DET_RETURN.

Top module: `osc_fail_supervisor`

## Requirements
- R1: After reset the register reads 0x04 (supervision off, oscillator selected), and sys_clk_sel is 1.
- R2: Bits 7:4 of rd_data always read 0, even after a write of 1s to them.
- R3: Only enable code 11 in bits 1:0 arms supervision. Codes 00, 01 and 10 leave the loss flag at 0 and never force the select, however long the main clock is quiet. The written code reads back unchanged.
- R4: Bit 2 is read/write (0 = main clock, 1 = oscillator), and sys_clk_sel always equals bit 2.
- R5: With code 11, TIMEOUT consecutive oscillator cycles with no synchronized main edge set bit 3 to 1 and bit 2 to 1 at the same clock edge. A main rising edge reaches the detector two oscillator edges after the first oscillator edge that samples it.
- R6: After a loss, bit 3 returns to 0 once RECOVER consecutive edges arrive, each within TIMEOUT cycles of the previous one. Bit 2 stays 1.
- R7: Bit 3 reads 0 whenever bits 1:0 are not 11, including immediately after supervision is disabled during a loss.
- R8: While bit 3 reads 1, a write with bit 2 = 0 leaves bit 2 at 1. Its bits 1:0 are still stored. With bit 3 at 0, such a write clears bit 2.
- R9: A write with prot_en = 0 changes nothing.
- R10: lso_off is 0 whenever bit 2 is 1, and otherwise equals lso_off_req.
- R11: When a stop event and a write of bit 2 = 0 occur at the same clock edge, bit 2 ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running on-chip oscillator clock; clocks all register logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_clk | input | 1 | Main clock being supervised |
| prot_en | input | 1 | Write protect release; writes count only when 1 |
| wr_stb | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational register read value |
| sys_clk_sel | output | 1 | System clock select: 0 main, 1 oscillator |
| lso_off_req | input | 1 | Off request for the low-speed oscillator from elsewhere |
| lso_off | output | 1 | Gated off request, held 0 while the oscillator is selected |

## Verification
The stop event that forces bit 2 high and a software write that clears bit 2 can land on the same oscillator edge. The bench provokes this by stopping the main clock and following its reference model until the gap counter is one cycle short of TIMEOUT with no edge in the synchronizer pipe. It then issues a protected write of 0x03 so that the write strobe is sampled on exactly the edge at which the stop is declared. It judges the result by requiring the register to read 0x0F afterwards: the select is forced and the loss flag is up. The same-edge write must not have won.

// File: rtl/clk_sup_pkg.sv
package clk_sup_pkg;

    typedef enum logic [1:0] {
        DET_OFF,
        DET_RUN,
        DET_LOST,
        DET_RETURN
    } det_state_e;

    localparam logic [1:0] EN_ARMED = 2'b11;

endpackage

// File: rtl/clk_sup_edge_sync.sv
module clk_sup_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic main_clk,
    input  logic clk,
    input  logic rst_n,
    output logic edge_seen
);
    logic             tog_q;
    logic [STAGES:0]  pipe_q;

    // toggles once per main-clock rising edge
    always_ff @(posedge main_clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], tog_q};
    end

    assign edge_seen = pipe_q[STAGES] ^ pipe_q[STAGES-1];
endmodule

// File: rtl/clk_sup_detector.sv
module clk_sup_detector
    import clk_sup_pkg::*;
#(
    parameter int TIMEOUT = 16,
    parameter int RECOVER = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_on,
    input  logic edge_seen,
    output logic stopped,
    output logic stop_hit
);
    localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam int RW = $clog2(RECOVER + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);
    localparam logic [RW-1:0] R_LAST = RW'(RECOVER - 1);

    det_state_e    st_q, st_n;
    logic [TW-1:0] gap_q, gap_n;
    logic [RW-1:0] ecnt_q, ecnt_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DET_OFF;
            gap_q  <= '0;
            ecnt_q <= '0;
        end else begin
            st_q   <= st_n;
            gap_q  <= gap_n;
            ecnt_q <= ecnt_n;
        end
    end

    // next state
    always_comb begin
        st_n   = st_q;
        gap_n  = gap_q;
        ecnt_n = ecnt_q;
        if (!en_on) begin
            st_n   = DET_OFF;
            gap_n  = '0;
            ecnt_n = '0;
        end else begin
            unique case (st_q)
                DET_OFF: begin
                    st_n  = DET_RUN;
                    gap_n = '0;
                end
                DET_RUN: begin
                    if (edge_seen) begin
                        gap_n = '0;
                    end else if (gap_q == T_LAST) begin
                        st_n  = DET_LOST;
                        gap_n = '0;
                    end else begin
                        gap_n = gap_q + 1'b1;
                    end
                end
                DET_LOST: begin
                    if (edge_seen) begin
                        gap_n  = '0;
                        ecnt_n = RW'(1);
                        st_n   = (R_LAST == '0) ? DET_RUN : DET_RETURN;
                    end
                end
                DET_RETURN: begin
                    if (edge_seen) begin
                        gap_n = '0;
                        if (ecnt_q == R_LAST) begin
                            st_n   = DET_RUN;
                            ecnt_n = '0;
                        end else begin
                            ecnt_n = ecnt_q + 1'b1;
                        end
                    end else if (gap_q == T_LAST) begin
                        st_n   = DET_LOST;
                        gap_n  = '0;
                        ecnt_n = '0;
                    end else begin
                        gap_n = gap_q + 1'b1;
                    end
                end
                default: st_n = DET_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        stopped  = (st_q == DET_LOST) || (st_q == DET_RETURN);
        stop_hit = en_on && (st_q == DET_RUN) && !edge_seen && (gap_q == T_LAST);
    end

    // R7
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_on |=> !stopped);

    // R5
    hit_enters_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> stopped);
endmodule

// File: rtl/clk_sup_csr.sv
module clk_sup_csr
    import clk_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       prot_en,
    input  logic [7:0] wr_data,
    input  logic       stopped,
    input  logic       stop_hit,
    output logic       en_on,
    output logic       sel,
    output logic [7:0] rd_data
);
    logic [1:0] en_q;
    logic       sel_q;
    logic       monitor;
    logic       wr_ok;
    logic       rsvd_unused;

    assign wr_ok       = wr_stb && prot_en;
    assign en_on       = (en_q == EN_ARMED);
    assign monitor     = en_on && stopped;
    assign rsvd_unused = ^{wr_data[7:3]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 2'b00;
            sel_q <= 1'b1;
        end else begin
            if (wr_ok) begin
                en_q <= wr_data[1:0];
                if (wr_data[2] || !monitor) sel_q <= wr_data[2];
            end
            if (stop_hit) sel_q <= 1'b1;
        end
    end

    assign sel     = sel_q;
    assign rd_data = {4'b0000, monitor, sel_q, en_q};

    // R11
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> sel_q);

    // R8
    lock_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (monitor && wr_ok && !wr_data[2]) |=> sel_q);

    // R9
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && !stop_hit) |=> ($stable(en_q) && $stable(sel_q)));
endmodule

// File: rtl/osc_fail_supervisor.sv
module osc_fail_supervisor #(
    parameter int TIMEOUT     = 16,
    parameter int RECOVER     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic       main_clk,
    input  logic       prot_en,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       sys_clk_sel,
    input  logic       lso_off_req,
    output logic       lso_off
);
    logic edge_seen;
    logic en_on;
    logic stopped;
    logic stop_hit;
    logic sel;

    clk_sup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .main_clk  (main_clk),
        .clk       (clk_osc),
        .rst_n     (rst_n),
        .edge_seen (edge_seen)
    );

    clk_sup_detector #(.TIMEOUT(TIMEOUT), .RECOVER(RECOVER)) u_det (
        .clk       (clk_osc),
        .rst_n     (rst_n),
        .en_on     (en_on),
        .edge_seen (edge_seen),
        .stopped   (stopped),
        .stop_hit  (stop_hit)
    );

    clk_sup_csr u_csr (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .prot_en  (prot_en),
        .wr_data  (wr_data),
        .stopped  (stopped),
        .stop_hit (stop_hit),
        .en_on    (en_on),
        .sel      (sel),
        .rd_data  (rd_data)
    );

    assign sys_clk_sel = sel;
    assign lso_off     = lso_off_req && !sel;
endmodule

// File: tb/osc_fail_supervisor_bench.sv
module osc_fail_supervisor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T_OUT = 16;
    localparam int R_EDG = 4;
    localparam int MHALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_clk = 1'b0;
    logic       prot_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       lso_off_req = 1'b1;
    logic       mclk_run = 1'b0;
    logic [7:0] rd_data;
    logic       sys_clk_sel;
    logic       lso_off;

    int n_chk = 0;
    int n_fail = 0;
    int rise_cnt = 0;
    int half_cnt = 0;

    // reference model state
    int       m_st = 0;   // 0 off, 1 run, 2 lost, 3 return
    int       m_gap = 0;
    int       m_ecnt = 0;
    bit [1:0] m_en = 2'b00;
    bit       m_sel = 1'b1;
    bit       p0 = 0, p1 = 0;
    int       seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_fail_supervisor #(.TIMEOUT(T_OUT), .RECOVER(R_EDG)) u_osc_fail_supervisor (
        .clk_osc     (clk),
        .rst_n       (rst_n),
        .main_clk    (main_clk),
        .prot_en     (prot_en),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .sys_clk_sel (sys_clk_sel),
        .lso_off_req (lso_off_req),
        .lso_off     (lso_off)
    );

    // main clock source, edges placed on oscillator falling edges
    always @(negedge clk) begin
        if (mclk_run) begin
            half_cnt = half_cnt + 1;
            if (half_cnt >= MHALF) begin
                half_cnt = 0;
                main_clk = ~main_clk;
                if (main_clk) rise_cnt = rise_cnt + 1;
            end
        end
    end

    // behavioural model, advanced on every oscillator edge
    always @(posedge clk) begin
        bit ev, on, mon, hit;
        bit [1:0] en_n;
        bit sel_n;
        if (!rst_n) begin
            m_st = 0; m_gap = 0; m_ecnt = 0; m_en = 2'b00; m_sel = 1'b1;
            p0 = 0; p1 = 0; seen = rise_cnt;
        end else begin
            ev = p1;
            p1 = p0;
            p0 = (rise_cnt != seen);
            seen = rise_cnt;
            on  = (m_en == 2'b11);
            mon = on && (m_st == 2 || m_st == 3);
            hit = on && m_st == 1 && !ev && m_gap == T_OUT - 1;
            if (!on) begin
                m_st = 0; m_gap = 0; m_ecnt = 0;
            end else if (m_st == 0) begin
                m_st = 1; m_gap = 0;
            end else if (m_st == 1) begin
                if (ev) m_gap = 0;
                else if (m_gap == T_OUT - 1) begin m_st = 2; m_gap = 0; end
                else m_gap = m_gap + 1;
            end else if (m_st == 2) begin
                if (ev) begin
                    m_gap = 0; m_ecnt = 1;
                    m_st = (R_EDG == 1) ? 1 : 3;
                end
            end else begin
                if (ev) begin
                    m_gap = 0;
                    if (m_ecnt == R_EDG - 1) begin m_st = 1; m_ecnt = 0; end
                    else m_ecnt = m_ecnt + 1;
                end else if (m_gap == T_OUT - 1) begin
                    m_st = 2; m_gap = 0; m_ecnt = 0;
                end else m_gap = m_gap + 1;
            end
            en_n = m_en;
            sel_n = m_sel;
            if (wr_stb && prot_en) begin
                en_n = wr_data[1:0];
                if (wr_data[2] || !mon) sel_n = wr_data[2];
            end
            if (hit) sel_n = 1'b1;
            m_en = en_n;
            m_sel = sel_n;
        end
    end

    function automatic bit [7:0] model_rd();
        bit mon;
        mon = (m_en == 2'b11) && (m_st == 2 || m_st == 3);
        return {4'b0000, mon, m_sel, m_en};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one oscillator cycle, then compare all outputs with the model
    task automatic step();
        @(negedge clk);
        if (rst_n) begin
            chk(rd_data == model_rd(), "R4 cycle rd_data", rd_data, model_rd());
            chk(sys_clk_sel == m_sel, "R4 cycle sys_clk_sel", sys_clk_sel, m_sel);
            chk(lso_off == (lso_off_req && !m_sel), "R10 cycle lso_off",
                lso_off, lso_off_req && !m_sel);
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr_reg(input bit [7:0] d, input bit p);
        step();
        wr_stb = 1'b1; wr_data = d; prot_en = p;
        step();
        wr_stb = 1'b0; prot_en = 1'b0;
    endtask

    initial begin
        bit found;
        steps(3);
        rst_n = 1'b1;
        step();
        chk(rd_data == 8'h04, "R1 reset value", rd_data, 8'h04);
        chk(sys_clk_sel == 1'b1, "R1 reset select", sys_clk_sel, 1);

        wr_reg(8'h03, 1'b0);
        step();
        chk(rd_data == 8'h04, "R9 protected write ignored", rd_data, 8'h04);

        wr_reg(8'hF0, 1'b1);
        step();
        chk(rd_data == 8'h00, "R2 reserved read zero", rd_data, 8'h00);
        chk(sys_clk_sel == 1'b0, "R4 main selected", sys_clk_sel, 0);
        chk(lso_off == 1'b1, "R10 off request passes", lso_off, 1);
        wr_reg(8'hF4, 1'b1);
        step();
        chk(rd_data == 8'h04, "R4 oscillator selected", rd_data, 8'h04);

        wr_reg(8'h01, 1'b1);
        steps(40);
        chk(rd_data == 8'h01, "R3 code 01 disabled", rd_data, 8'h01);
        wr_reg(8'h02, 1'b1);
        steps(40);
        chk(rd_data == 8'h02, "R3 code 10 disabled", rd_data, 8'h02);

        mclk_run = 1'b1;
        wr_reg(8'h03, 1'b1);
        steps(40);
        chk(rd_data == 8'h03, "R5 running no loss", rd_data, 8'h03);
        mclk_run = 1'b0;
        steps(30);
        chk(rd_data == 8'h0F, "R5 loss detected", rd_data, 8'h0F);
        chk(lso_off == 1'b0, "R10 off forced low", lso_off, 0);

        wr_reg(8'h03, 1'b1);
        step();
        chk(rd_data == 8'h0F, "R8 clear blocked", rd_data, 8'h0F);

        mclk_run = 1'b1;
        steps(40);
        chk(rd_data == 8'h07, "R6 loss cleared", rd_data, 8'h07);
        wr_reg(8'h03, 1'b1);
        step();
        chk(rd_data == 8'h03, "R8 clear allowed", rd_data, 8'h03);

        mclk_run = 1'b0;
        steps(30);
        chk(rd_data == 8'h0F, "R5 second loss", rd_data, 8'h0F);
        wr_reg(8'h00, 1'b1);
        step();
        chk(rd_data == 8'h04, "R7 disable clears flag", rd_data, 8'h04);

        mclk_run = 1'b1;
        wr_reg(8'h03, 1'b1);
        steps(30);
        mclk_run = 1'b0;
        found = 0;
        for (int i = 0; i < 100 && !found; i++) begin
            step();
            if (m_st == 1 && m_gap == T_OUT - 1 && !p1 && !p0) begin
                wr_stb = 1'b1; wr_data = 8'h03; prot_en = 1'b1;
                found = 1;
            end
        end
        step();
        wr_stb = 1'b0; prot_en = 1'b0;
        chk(found, "R11 collision reached", found, 1);
        chk(rd_data == 8'h0F, "R11 hardware set wins", rd_data, 8'h0F);
        steps(5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end
endmodule